// File: doc/BRIEF.md
# Function-level reset handshake controller

The block sits in a multi-function endpoint between the configuration write path and the application logic. For each function it holds a 16-bit device control register. Configuration writes reach that register through a plain write strobe that carries a function index, a register address, data and two byte enables. Writing a one to the reset-request bit (bit 15) starts a reset of that function. Three things then happen:

- The function's writable non-sticky control bits return to their reset values, while the sticky bits keep theirs.
- The function's reset-active output rises toward the application.
- The function reads as disabled.

The function stays disabled until the application pulses that function's cleanup-done input. One cycle later, reset-active falls again and the function is enabled.

A small request tracker on the application side keeps an outstanding-request count for each function. While a function's reset is active, the tracker forces that count to zero and refuses new requests from the function. Requests use a valid/ready port. On this port `req_ready` is low while the function is in reset or its count is full, and a request counts only when valid and ready are both high.

Completions pass through a valid/ready stream. A completion whose function is not in reset is forwarded, and back-pressure from `cpl_out_ready` reaches `cpl_in_ready` in the same cycle. A completion whose function is in reset is accepted with `cpl_in_ready` high and dropped. So no completion for a request issued before the reset can leave the block once the function is enabled again.

Top module: `flr_ctrl`

## Requirements
- R1: A write strobe whose address equals the control register address (default 8'h08) updates only the writable bits (mask 16'h7FFF by default) of the addressed function. Byte enable bit 0 covers bits 7:0 and bit 1 covers bits 15:8. Writes to any other address change nothing. Bit 15 always reads back as zero.
- R2: A write to the control register with byte enable bit 1 and data bit 15 set, to a function in the idle state, raises that function's `flr_active` bit and drops its `fn_enabled` bit at the next clock edge.
- R3: In the cycle a reset starts, the function's non-sticky bits take the reset value (default 16'h2010), the sticky bits (mask 16'h0F00 by default) keep their values, and the data of the triggering write is discarded.
- R4: A one-cycle `flr_done` pulse while the function's reset is active moves it to a wait state, keeping `flr_active` high for one more cycle. `flr_active` then falls and `fn_enabled` rises one cycle later, two edges after the pulse. A pulse while the function is idle has no effect.
- R5: A reset-request write to a function that is not idle starts no new reset and clears no bits. Its other writable bits are written as a normal write.
- R6: `req_ready` is high only when the function named by `req_fn` is not in reset and its outstanding count is below the maximum (7 by default). Each accepted request increments that count.
- R7: When the completion's function is not in reset, the completion is forwarded unchanged and `cpl_in_ready` equals `cpl_out_ready`. When that function is in reset, `cpl_out_valid` is low and `cpl_in_ready` is high, so the completion is dropped. An accepted completion decrements a nonzero count.
- R8: While a function's reset is active, its outstanding count is cleared to zero from the edge after reset-active rises.
- R9: Functions are independent: a reset of one function leaves the registers, counts, request acceptance and enable of the others unchanged.
- R10: After reset, every `flr_active` bit is low, every `fn_enabled` bit is high, every control register holds the reset value and every count is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_fn | input | FN_W | Function index of the write |
| cfg_wr_addr | input | ADDR_W | Register address of the write |
| cfg_wr_data | input | 16 | Write data |
| cfg_wr_be | input | 2 | Byte enables |
| cfg_rd_fn | input | FN_W | Function selected for the readback outputs |
| cfg_rd_data | output | 16 | Control register of the selected function |
| pend_cnt | output | CNT_W | Outstanding count of the selected function |
| flr_active | output | NUM_FN | Reset-active, one bit per function |
| flr_done | input | NUM_FN | Cleanup-done pulses from the application |
| fn_enabled | output | NUM_FN | High when the function is enabled |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_fn | input | FN_W | Function issuing the request |
| cpl_in_valid | input | 1 | Incoming completion valid |
| cpl_in_ready | output | 1 | Incoming completion ready |
| cpl_in_fn | input | FN_W | Function of the completion |
| cpl_in_data | input | DATA_W | Completion payload |
| cpl_out_valid | output | 1 | Forwarded completion valid |
| cpl_out_ready | input | 1 | Downstream ready |
| cpl_out_fn | output | FN_W | Function of the forwarded completion |
| cpl_out_data | output | DATA_W | Forwarded payload |

## Verification
The bench builds the block with its default parameters: four functions, a 3-bit outstanding count and 8-bit completion data. Four functions allow one reset to overlap traffic and register state on untouched neighbours. The small count limit lets the saturation boundary be reached after seven requests. The default sticky and writable masks make a byte-enabled write followed by a reset leave distinct, hand-computable register values.

// File: rtl/flr_pkg.sv
package flr_pkg;
  localparam int CTL_W   = 16;
  localparam int FLR_BIT = 15;

  typedef enum logic [1:0] {
    FN_IDLE   = 2'd0,
    FN_ACTIVE = 2'd1,
    FN_WAIT   = 2'd2
  } fn_state_e;
endpackage

// File: rtl/flr_fn_unit.sv
module flr_fn_unit
  import flr_pkg::*;
#(
  parameter logic [CTL_W-1:0] RESET_VAL = 16'h2010,
  parameter logic [CTL_W-1:0] WR_MASK   = 16'h7FFF,
  parameter logic [CTL_W-1:0] STICKY    = 16'h0F00
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_hit,
  input  logic [CTL_W-1:0] wr_data,
  input  logic [1:0]       wr_be,
  input  logic             done,
  output logic [CTL_W-1:0] ctl,
  output logic             active
);
  localparam logic [CTL_W-1:0] FLR_ONE = CTL_W'(1) << FLR_BIT;

  fn_state_e        state;
  logic             trig;
  logic [CTL_W-1:0] lane_mask;
  logic [CTL_W-1:0] merged;
  logic [CTL_W-1:0] cleared;

  always_comb begin
    trig      = wr_hit && wr_be[1] && wr_data[FLR_BIT];
    lane_mask = {{8{wr_be[1]}}, {8{wr_be[0]}}} & WR_MASK & ~FLR_ONE;
    merged    = (ctl & ~lane_mask) | (wr_data & lane_mask);
    cleared   = (ctl & STICKY) | (RESET_VAL & ~STICKY);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= FN_IDLE;
      ctl   <= RESET_VAL & ~FLR_ONE;
    end else begin
      case (state)
        FN_IDLE:   if (trig) state <= FN_ACTIVE;
        FN_ACTIVE: if (done) state <= FN_WAIT;
        default:   state <= FN_IDLE;
      endcase
      if (trig && state == FN_IDLE) ctl <= cleared & ~FLR_ONE;
      else if (wr_hit)              ctl <= merged;
    end
  end

  assign active = (state != FN_IDLE);
endmodule

// File: rtl/flr_req_tracker.sv
module flr_req_tracker #(
  parameter int NUM_FN = 4,
  parameter int FN_W   = 2,
  parameter int CNT_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_FN-1:0] active,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FN_W-1:0]   req_fn,
  input  logic              cpl_in_valid,
  output logic              cpl_in_ready,
  input  logic [FN_W-1:0]   cpl_in_fn,
  input  logic [DATA_W-1:0] cpl_in_data,
  output logic              cpl_out_valid,
  input  logic              cpl_out_ready,
  output logic [FN_W-1:0]   cpl_out_fn,
  output logic [DATA_W-1:0] cpl_out_data,
  input  logic [FN_W-1:0]   sel_fn,
  output logic [CNT_W-1:0]  sel_cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt [NUM_FN];
  logic             req_ok, cpl_ok, cpl_blocked;

  always_comb begin
    req_ok       = (32'(req_fn) < NUM_FN);
    cpl_ok       = (32'(cpl_in_fn) < NUM_FN);
    req_ready    = req_ok && !active[req_fn] && (cnt[req_fn] != CNT_MAX);
    cpl_blocked  = cpl_ok && active[cpl_in_fn];
    cpl_out_valid = cpl_in_valid && !cpl_blocked;
    cpl_in_ready  = cpl_blocked ? 1'b1 : cpl_out_ready;
    cpl_out_fn    = cpl_in_fn;
    cpl_out_data  = cpl_in_data;
    sel_cnt       = (32'(sel_fn) < NUM_FN) ? cnt[sel_fn] : '0;
  end

  for (genvar i = 0; i < NUM_FN; i++) begin : g_cnt
    logic inc, dec;
    always_comb begin
      inc = req_valid && req_ready && (32'(req_fn) == i);
      dec = cpl_in_valid && cpl_in_ready && (32'(cpl_in_fn) == i) && (cnt[i] != '0);
    end
    always_ff @(posedge clk) begin
      if (!rst_n || active[i]) cnt[i] <= '0;
      else if (inc && !dec)    cnt[i] <= cnt[i] + CNT_W'(1);
      else if (dec && !inc)    cnt[i] <= cnt[i] - CNT_W'(1);
    end
  end
endmodule

// File: rtl/flr_ctrl.sv
module flr_ctrl
  import flr_pkg::*;
#(
  parameter int NUM_FN = 4,
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 3,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] CTL_ADDR  = 8'h08,
  parameter logic [CTL_W-1:0]  RESET_VAL = 16'h2010,
  parameter logic [CTL_W-1:0]  WR_MASK   = 16'h7FFF,
  parameter logic [CTL_W-1:0]  STICKY    = 16'h0F00,
  localparam int FN_W = (NUM_FN > 1) ? $clog2(NUM_FN) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_en,
  input  logic [FN_W-1:0]   cfg_wr_fn,
  input  logic [ADDR_W-1:0] cfg_wr_addr,
  input  logic [CTL_W-1:0]  cfg_wr_data,
  input  logic [1:0]        cfg_wr_be,
  input  logic [FN_W-1:0]   cfg_rd_fn,
  output logic [CTL_W-1:0]  cfg_rd_data,
  output logic [CNT_W-1:0]  pend_cnt,
  output logic [NUM_FN-1:0] flr_active,
  input  logic [NUM_FN-1:0] flr_done,
  output logic [NUM_FN-1:0] fn_enabled,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [FN_W-1:0]   req_fn,
  input  logic              cpl_in_valid,
  output logic              cpl_in_ready,
  input  logic [FN_W-1:0]   cpl_in_fn,
  input  logic [DATA_W-1:0] cpl_in_data,
  output logic              cpl_out_valid,
  input  logic              cpl_out_ready,
  output logic [FN_W-1:0]   cpl_out_fn,
  output logic [DATA_W-1:0] cpl_out_data
);
  logic [CTL_W-1:0] ctl [NUM_FN];

  for (genvar i = 0; i < NUM_FN; i++) begin : g_fn
    logic hit;
    assign hit = cfg_wr_en && (cfg_wr_addr == CTL_ADDR) && (32'(cfg_wr_fn) == i);
    flr_fn_unit #(
      .RESET_VAL(RESET_VAL), .WR_MASK(WR_MASK), .STICKY(STICKY)
    ) i_unit (
      .clk(clk), .rst_n(rst_n), .wr_hit(hit), .wr_data(cfg_wr_data),
      .wr_be(cfg_wr_be), .done(flr_done[i]), .ctl(ctl[i]), .active(flr_active[i])
    );
  end

  assign fn_enabled  = ~flr_active;
  assign cfg_rd_data = (32'(cfg_rd_fn) < NUM_FN) ? ctl[cfg_rd_fn] : '0;

  flr_req_tracker #(
    .NUM_FN(NUM_FN), .FN_W(FN_W), .CNT_W(CNT_W), .DATA_W(DATA_W)
  ) i_trk (
    .clk(clk), .rst_n(rst_n), .active(flr_active),
    .req_valid(req_valid), .req_ready(req_ready), .req_fn(req_fn),
    .cpl_in_valid(cpl_in_valid), .cpl_in_ready(cpl_in_ready),
    .cpl_in_fn(cpl_in_fn), .cpl_in_data(cpl_in_data),
    .cpl_out_valid(cpl_out_valid), .cpl_out_ready(cpl_out_ready),
    .cpl_out_fn(cpl_out_fn), .cpl_out_data(cpl_out_data),
    .sel_fn(cfg_rd_fn), .sel_cnt(pend_cnt)
  );
endmodule

// File: rtl/flr_ctrl_chk.sv
module flr_ctrl_chk #(
  parameter int NUM_FN = 4,
  parameter int ADDR_W = 8,
  parameter int FN_W   = 2,
  parameter logic [ADDR_W-1:0] CTL_ADDR = 8'h08,
  parameter logic [15:0]       STICKY   = 16'h0F00
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr_en,
  input logic [FN_W-1:0]   cfg_wr_fn,
  input logic [ADDR_W-1:0] cfg_wr_addr,
  input logic [15:0]       cfg_wr_data,
  input logic [1:0]        cfg_wr_be,
  input logic [FN_W-1:0]   cfg_rd_fn,
  input logic [15:0]       cfg_rd_data,
  input logic [NUM_FN-1:0] flr_active,
  input logic [NUM_FN-1:0] flr_done,
  input logic              req_valid,
  input logic              req_ready,
  input logic [FN_W-1:0]   req_fn,
  input logic              cpl_out_valid,
  input logic [FN_W-1:0]   cpl_in_fn
);
  logic req_trig;
  assign req_trig = cfg_wr_en && (cfg_wr_addr == CTL_ADDR) && cfg_wr_be[1] && cfg_wr_data[15];

  for (genvar i = 0; i < NUM_FN; i++) begin : g_p
    assert_rise_after_trigger_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flr_active[i]) |-> $past(req_trig && (32'(cfg_wr_fn) == i)));
    assert_fall_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flr_active[i]) |-> $past(flr_done[i], 2));
  end

  assert_no_cpl_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_out_valid |-> !flr_active[cpl_in_fn]);
  assert_no_req_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |-> !flr_active[req_fn]);
  assert_sticky_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_trig && cfg_wr_fn == cfg_rd_fn && !flr_active[cfg_rd_fn]) |=>
      (!$stable(cfg_rd_fn) || ((cfg_rd_data & STICKY) == ($past(cfg_rd_data) & STICKY))));
endmodule

bind flr_ctrl flr_ctrl_chk #(
  .NUM_FN(NUM_FN), .ADDR_W(ADDR_W), .FN_W(FN_W), .CTL_ADDR(CTL_ADDR), .STICKY(STICKY)
) i_chk (.*);

// File: tb/test_flr_ctrl.sv
module test_flr_ctrl;
  localparam int PERIOD = 10;
  localparam int NF = 4;

  logic clk = 0, rst_n = 0;
  logic cfg_wr_en = 0;
  logic [1:0] cfg_wr_fn = 0, cfg_rd_fn = 0, req_fn = 0, cpl_in_fn = 0, cpl_out_fn;
  logic [7:0] cfg_wr_addr = 8'h08;
  logic [15:0] cfg_wr_data = 0, cfg_rd_data;
  logic [1:0] cfg_wr_be = 0;
  logic [2:0] pend_cnt;
  logic [NF-1:0] flr_active, flr_done = 0, fn_enabled;
  logic req_valid = 0, req_ready, cpl_in_valid = 0, cpl_in_ready;
  logic cpl_out_valid, cpl_out_ready = 1;
  logic [7:0] cpl_in_data = 0, cpl_out_data;

  int nchk = 0, nfail = 0;
  bit done_flag = 0;

  always #(PERIOD/2) clk = ~clk;

  flr_ctrl i_flr_ctrl (.*);

  typedef struct packed {
    logic [1:0] fn; logic [1:0] be; logic [15:0] data; logic [15:0] exp;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{2'd0, 2'b11, 16'h1234, 16'h1234},
    '{2'd1, 2'b01, 16'hFFFF, 16'h20FF},
    '{2'd1, 2'b10, 16'h3BCD, 16'h3BFF},
    '{2'd0, 2'b10, 16'h8F55, 16'h2210},
    '{2'd1, 2'b10, 16'h8000, 16'h2B10},
    '{2'd2, 2'b00, 16'hFFFF, 16'h2010},
    '{2'd3, 2'b11, 16'h7FFF, 16'h7FFF},
    '{2'd3, 2'b11, 16'hFFFF, 16'h2F10}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cfg_write(logic [1:0] fn, logic [7:0] addr, logic [1:0] be, logic [15:0] d);
    @(negedge clk);
    cfg_wr_en = 1; cfg_wr_fn = fn; cfg_wr_addr = addr; cfg_wr_be = be; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_en = 0;
  endtask

  task automatic pulse_done(int fn);
    @(negedge clk); flr_done[fn] = 1;
    @(negedge clk); flr_done[fn] = 0;
  endtask

  task automatic send_req(logic [1:0] fn, logic exp_rdy, string req);
    @(negedge clk);
    req_valid = 1; req_fn = fn;
    #1 chk(req, req_ready, exp_rdy);
    @(negedge clk);
    req_valid = 0;
  endtask

  initial begin
    #(PERIOD * 100000);
    if (!done_flag) begin
      nfail++; nchk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk("R10 active", 32'(flr_active), 0);
    chk("R10 enabled", 32'(fn_enabled), 32'hF);
    for (int f = 0; f < NF; f++) begin
      cfg_rd_fn = 2'(f);
      #1 chk("R10 ctl", 32'(cfg_rd_data), 32'h2010);
      chk("R10 pend", 32'(pend_cnt), 0);
    end

    // vector table: R1 byte-lane writes, R2/R3 reset trigger and clearing
    for (int v = 0; v < 8; v++) begin
      logic trig;
      trig = VEC[v].be[1] && VEC[v].data[15];
      cfg_rd_fn = VEC[v].fn;
      cfg_write(VEC[v].fn, 8'h08, VEC[v].be, VEC[v].data);
      chk(trig ? "R3 ctl after reset" : "R1 ctl write", 32'(cfg_rd_data), 32'(VEC[v].exp));
      chk("R2 active", 32'(flr_active[VEC[v].fn]), 32'(trig));
      chk("R2 enabled", 32'(fn_enabled[VEC[v].fn]), 32'(!trig));
      if (trig) begin
        pulse_done(VEC[v].fn);
        chk("R4 still active in wait", 32'(flr_active[VEC[v].fn]), 1);
        @(negedge clk);
        chk("R4 released", 32'(flr_active[VEC[v].fn]), 0);
        chk("R4 enabled", 32'(fn_enabled[VEC[v].fn]), 1);
      end
    end

    // R1 other address ignored
    cfg_rd_fn = 2;
    cfg_write(2, 8'h09, 2'b11, 16'h1111);
    chk("R1 other addr", 32'(cfg_rd_data), 32'h2010);
    cfg_write(2, 8'h09, 2'b11, 16'h8000);
    chk("R1 other addr no reset", 32'(flr_active), 0);

    // R4 done while idle ignored
    pulse_done(2);
    @(negedge clk);
    chk("R4 idle done", 32'(flr_active), 0);

    // R5 second trigger while active
    cfg_rd_fn = 0;
    cfg_write(0, 8'h08, 2'b10, 16'h8000);
    chk("R3 ctl fn0", 32'(cfg_rd_data), 32'h2210);
    cfg_write(0, 8'h08, 2'b11, 16'h8077);
    chk("R5 no reclear", 32'(cfg_rd_data), 32'h0077);
    chk("R5 still active", 32'(flr_active[0]), 1);
    pulse_done(0);
    @(negedge clk);
    chk("R5 single done releases", 32'(flr_active[0]), 0);

    // tracker R6 R7
    cfg_rd_fn = 1;
    for (int k = 0; k < 3; k++) send_req(1, 1, "R6 accept");
    chk("R6 count", 32'(pend_cnt), 3);
    @(negedge clk);
    cpl_in_valid = 1; cpl_in_fn = 1; cpl_in_data = 8'hAA; cpl_out_ready = 1;
    #1 chk("R7 forward valid", 32'(cpl_out_valid), 1);
    chk("R7 forward data", 32'(cpl_out_data), 32'hAA);
    chk("R7 in ready", 32'(cpl_in_ready), 1);
    @(negedge clk);
    cpl_out_ready = 0;
    chk("R7 decrement", 32'(pend_cnt), 2);
    #1 chk("R7 backpressure", 32'(cpl_in_ready), 0);
    @(negedge clk);
    chk("R7 held count", 32'(pend_cnt), 2);
    cpl_in_valid = 0; cpl_out_ready = 1;

    // reset fn1 with pending requests: R8, R7 drop, R9 independence
    cfg_write(1, 8'h08, 2'b10, 16'h8000);
    chk("R3 ctl fn1", 32'(cfg_rd_data), 32'h2B10);
    cpl_in_valid = 1; cpl_in_fn = 1; cpl_out_ready = 0;
    #1 chk("R7 drop valid", 32'(cpl_out_valid), 0);
    chk("R7 drop ready", 32'(cpl_in_ready), 1);
    @(negedge clk);
    cpl_in_valid = 0; cpl_out_ready = 1;
    chk("R8 flushed", 32'(pend_cnt), 0);
    send_req(1, 0, "R6 blocked in reset");
    send_req(3, 1, "R9 other fn accepts");
    chk("R9 other enabled", 32'(fn_enabled), 32'hD);
    cfg_rd_fn = 3;
    #1 chk("R9 other count", 32'(pend_cnt), 1);
    chk("R9 other ctl", 32'(cfg_rd_data), 32'h2F10);
    pulse_done(1);
    @(negedge clk);
    cfg_rd_fn = 1;
    #1 chk("R8 count after release", 32'(pend_cnt), 0);
    send_req(1, 1, "R6 accept after release");

    // R6 saturation on fn2
    for (int k = 0; k < 7; k++) send_req(2, 1, "R6 fill");
    send_req(2, 0, "R6 full");
    cfg_rd_fn = 2;
    #1 chk("R6 max count", 32'(pend_cnt), 7);

    done_flag = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule